// File: doc/BRIEF.md
# Subtract-and-Branch Instruction Emulation Sequencer

This block stands in for a failed arithmetic unit by emulating one integer operation at a time. The only arithmetic it has is a single primitive: subtract cell A from cell B, write the difference back into B, and branch to a target step if the new value is zero or negative. A caller presents an opcode with two 32-bit operands and pulses `start`. The block latches the operands into two cells, X (operand `opa`) and Y (operand `opb`). In the same cycle it decodes the opcode to an entry address in a small microcode ROM, sets the 12-bit step counter to that address and loads the first control word. Each following cycle performs one subtraction. The control word in force selects the source cell, the destination cell and the branch target. There is no register file: all working values live in the cells X, Y, a scratch cell Z and a fixed constant-one cell.

The control logic is a two-state machine. `S_IDLE` waits for `start`. On the *accept* transition, a supported opcode moves the machine to `S_RUN`. On the *reject* path, an unsupported opcode keeps it in `S_IDLE` and raises an error with the completion pulse. `S_RUN` executes one control word per cycle. When it reaches a control word marked as a return, it takes the *return* transition back to `S_IDLE`. On that transition it registers the result from the opcode's result cell and pulses `done`. The scratch cell Z is cleared only by reset and is never loaded from the operands, so every sequence must leave it at zero.

Top module: `subleq_emu`

## Requirements
- R1: After reset, `done`, `err` and `busy` are low and `result` is zero.
- R2: Opcode encoding: 0 ADD, 1 SUB, 2 RSB, 3 INC, 4 DEC, 5 MOV. A `start` seen in idle with one of these opcodes latches `opa` and `opb` and makes `busy` high from the next cycle.
- R3: Each step computes B := B − A on 32-bit two's complement values. If the new B is zero or has bit 31 set, the step counter takes the control word's target; otherwise it advances by one.
- R4: ADD returns `opb + opa` modulo 2^32, with `done` high 4 cycles after the accepting clock edge.
- R5: SUB returns `opb − opa` and RSB returns `opa − opb`, each with `done` 2 cycles after the accepting edge.
- R6: INC returns `opb + 1` with `done` after 4 cycles. DEC returns `opb − 1` with `done` after 2 cycles. Both wrap modulo 2^32.
- R7: MOV returns `opa` with `done` 5 cycles after the accepting edge.
- R8: The scratch cell is zero whenever `done` is high, so operations issued back to back, each in the cycle its predecessor completes, all return correct results.
- R9: Opcodes 6 and 7 are unsupported. They produce `done` and `err` together in the cycle right after the accepting edge, with `result` zero.
- R10: `start` while `busy` is high is ignored: no extra `done`, and the running operation's result and timing are unaffected.
- R11: `done` is a one-cycle pulse per accepted operation, and `busy` is low whenever `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to emulate `opcode`; sampled in idle only |
| opcode | input | 3 | Operation code (R2 encoding) |
| opa | input | 32 | First operand, latched into cell X |
| opb | input | 32 | Second operand, latched into cell Y |
| busy | output | 1 | A microcode sequence is running |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | High with `done` for an unsupported opcode |
| result | output | 32 | Result of the last completed operation |

## Verification
The hardest condition to reach from the ports is a scratch cell left nonzero, or a wrong branch out of a sequence's final clearing step. Neither corrupts the operation that causes it. The damage appears only in a later operation that reads Z, or as a run into the wrong microcode. The stimulus therefore issues operations back to back, each in the very cycle the previous `done` appears, and checks each result and its exact latency. In another case, `start` is held high with a different opcode and different operands through a running ADD; the bench expects exactly one completion, carrying the ADD's result.

// File: rtl/subleq_pkg.sv
package subleq_pkg;

    localparam int PCW = 12;
    localparam int OPW = 3;

    typedef enum logic [1:0] {
        CELL_X   = 2'd0,
        CELL_Y   = 2'd1,
        CELL_Z   = 2'd2,
        CELL_ONE = 2'd3
    } cell_e;

    typedef enum logic [OPW-1:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_RSB = 3'd2,
        OP_INC = 3'd3,
        OP_DEC = 3'd4,
        OP_MOV = 3'd5
    } op_e;

    typedef struct packed {
        logic           halt;
        cell_e          src;
        cell_e          dst;
        logic [PCW-1:0] target;
    } cword_t;

    // Entry points of each microcode routine
    localparam logic [PCW-1:0] ENT_ADD = 12'd1;
    localparam logic [PCW-1:0] ENT_INC = 12'd4;
    localparam logic [PCW-1:0] ENT_MOV = 12'd7;
    localparam logic [PCW-1:0] ENT_DEC = 12'd11;
    localparam logic [PCW-1:0] ENT_SUB = 12'd13;
    localparam logic [PCW-1:0] ENT_RSB = 12'd15;

    function automatic cword_t mk_step(cell_e a, cell_e b, int unsigned tgt);
        cword_t w;
        w.halt   = 1'b0;
        w.src    = a;
        w.dst    = b;
        w.target = PCW'(tgt);
        return w;
    endfunction

    function automatic cword_t mk_ret();
        cword_t w;
        w.halt   = 1'b1;
        w.src    = CELL_Z;
        w.dst    = CELL_Z;
        w.target = '0;
        return w;
    endfunction

    // Microcode: routines ending with a Z,Z clear always branch to the shared
    // return word at address 0; single-step routines own a return word.
    function automatic cword_t urom_word(int unsigned a);
        case (a)
            1:       return mk_step(CELL_X,   CELL_Z, 2);
            2:       return mk_step(CELL_Z,   CELL_Y, 3);
            3:       return mk_step(CELL_Z,   CELL_Z, 0);
            4:       return mk_step(CELL_ONE, CELL_Z, 5);
            5:       return mk_step(CELL_Z,   CELL_Y, 6);
            6:       return mk_step(CELL_Z,   CELL_Z, 0);
            7:       return mk_step(CELL_Y,   CELL_Y, 8);
            8:       return mk_step(CELL_X,   CELL_Z, 9);
            9:       return mk_step(CELL_Z,   CELL_Y, 10);
            10:      return mk_step(CELL_Z,   CELL_Z, 0);
            11:      return mk_step(CELL_ONE, CELL_Y, 12);
            13:      return mk_step(CELL_X,   CELL_Y, 14);
            15:      return mk_step(CELL_Y,   CELL_X, 16);
            default: return mk_ret();
        endcase
    endfunction

endpackage

// File: rtl/subleq_decode.sv
module subleq_decode
    import subleq_pkg::*;
(
    input  logic [OPW-1:0] op,
    output logic           valid,
    output logic [PCW-1:0] entry,
    output cell_e          res_cell
);

    always_comb begin
        valid    = 1'b1;
        entry    = '0;
        res_cell = CELL_Y;
        case (op)
            OP_ADD:  entry = ENT_ADD;
            OP_SUB:  entry = ENT_SUB;
            OP_RSB: begin
                entry    = ENT_RSB;
                res_cell = CELL_X;
            end
            OP_INC:  entry = ENT_INC;
            OP_DEC:  entry = ENT_DEC;
            OP_MOV:  entry = ENT_MOV;
            default: valid = 1'b0;
        endcase
    end

endmodule

// File: rtl/subleq_urom.sv
module subleq_urom
    import subleq_pkg::*;
#(
    parameter int DEPTH = 32
) (
    input  logic [PCW-1:0] addr,
    output cword_t         word
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    cword_t table_q [DEPTH];

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_word
            assign table_q[g] = urom_word(g);
        end
    endgenerate

    always_comb begin
        if (addr >= PCW'(DEPTH)) word = mk_ret();
        else                     word = table_q[addr[AW-1:0]];
    end

endmodule

// File: rtl/subleq_cells.sv
module subleq_cells
    import subleq_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] opa,
    input  logic [DW-1:0] opb,
    input  logic          step,
    input  cell_e         src,
    input  cell_e         dst,
    input  cell_e         res_sel,
    output logic          le0,
    output logic [DW-1:0] res_val,
    output logic [DW-1:0] z_val
);

    localparam int NCELL = 3;
    localparam logic [DW-1:0] ONE = DW'(1);

    logic [DW-1:0] cell_q [NCELL];
    logic [DW-1:0] a_v, b_v, diff;

    function automatic logic [DW-1:0] pick(cell_e c, logic [DW-1:0] x,
                                           logic [DW-1:0] y, logic [DW-1:0] z);
        case (c)
            CELL_X:  return x;
            CELL_Y:  return y;
            CELL_Z:  return z;
            default: return ONE;
        endcase
    endfunction

    always_comb begin
        a_v     = pick(src, cell_q[0], cell_q[1], cell_q[2]);
        b_v     = pick(dst, cell_q[0], cell_q[1], cell_q[2]);
        res_val = pick(res_sel, cell_q[0], cell_q[1], cell_q[2]);
        diff    = b_v - a_v;
        le0     = (diff == '0) || diff[DW-1];
        z_val   = cell_q[2];
    end

    generate
        for (genvar g = 0; g < NCELL; g++) begin : g_cell
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cell_q[g] <= '0;
                end else if (load && g == 0) begin
                    cell_q[g] <= opa;
                end else if (load && g == 1) begin
                    cell_q[g] <= opb;
                end else if (step && dst == cell_e'(g)) begin
                    cell_q[g] <= diff;
                end
            end
        end
    endgenerate

    // R3: the constant cell is never a destination
    p_const_ro_r3: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> dst != CELL_ONE);

    // R3: a step writes the difference into its destination
    p_step_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && dst == CELL_Y && src == CELL_X) |=> cell_q[1] == $past(cell_q[1] - cell_q[0]));

endmodule

// File: rtl/subleq_emu.sv
module subleq_emu
    import subleq_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int UROM_DEPTH = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        opcode,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [DATA_W-1:0] result
);

    typedef enum logic {S_IDLE, S_RUN} state_e;

    state_e state_q, state_d;

    logic [PCW-1:0]    pc_q, npc, fetch_addr;
    cword_t            cw_q, rom_word;
    cell_e             res_cell_q;
    logic              dec_valid;
    logic [PCW-1:0]    dec_entry;
    cell_e             dec_res;
    logic              accept, reject, load, step, finish, le0;
    logic [DATA_W-1:0] res_val, z_val;
    logic              done_q, err_q;
    logic [DATA_W-1:0] result_q;

    subleq_decode u_dec (
        .op       (opcode),
        .valid    (dec_valid),
        .entry    (dec_entry),
        .res_cell (dec_res)
    );

    subleq_urom #(.DEPTH(UROM_DEPTH)) u_rom (
        .addr (fetch_addr),
        .word (rom_word)
    );

    subleq_cells #(.DW(DATA_W)) u_cells (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .opa     (opa),
        .opb     (opb),
        .step    (step),
        .src     (cw_q.src),
        .dst     (cw_q.dst),
        .res_sel (res_cell_q),
        .le0     (le0),
        .res_val (res_val),
        .z_val   (z_val)
    );

    always_comb begin
        accept     = (state_q == S_IDLE) && start;
        load       = accept && dec_valid;
        reject     = accept && !dec_valid;
        step       = (state_q == S_RUN) && !cw_q.halt;
        finish     = (state_q == S_RUN) && cw_q.halt;
        npc        = le0 ? cw_q.target : pc_q + PCW'(1);
        fetch_addr = load ? dec_entry : npc;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (load)   state_d = S_RUN;
            S_RUN:  if (finish) state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Sequencer and output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q       <= '0;
            cw_q       <= mk_ret();
            res_cell_q <= CELL_Y;
            done_q     <= 1'b0;
            err_q      <= 1'b0;
            result_q   <= '0;
        end else begin
            done_q <= finish || reject;
            err_q  <= reject;
            if (load) begin
                pc_q       <= dec_entry;
                cw_q       <= rom_word;
                res_cell_q <= dec_res;
            end else if (step) begin
                pc_q <= npc;
                cw_q <= rom_word;
            end
            if (finish)      result_q <= res_val;
            else if (reject) result_q <= '0;
        end
    end

    assign busy   = (state_q == S_RUN);
    assign done   = done_q;
    assign err    = err_q;
    assign result = result_q;

    // R2: a supported request starts a run
    p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> busy);

    // R3: branch on zero or negative difference
    p_branch_taken_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && le0) |=> pc_q == $past(cw_q.target));

    p_branch_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !le0) |=> pc_q == $past(pc_q) + PCW'(1));

    // R8: scratch cell is clear on every completion
    p_zero_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> z_val == '0);

    // R9: error only accompanies a completion pulse
    p_err_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);

    // R10: a running sequence keeps running until its return word
    p_no_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> busy);

    // R11: completion is seen only while idle
    p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

endmodule

// File: tb/sim_subleq_emu.sv
module sim_subleq_emu;

    typedef struct {
        logic [31:0] res;
        logic        err;
        int          cyc;
        string       req;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  opcode = '0;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic        busy, done, err;
    logic [31:0] result;

    int    n_chk = 0;
    int    n_bad = 0;
    int    cyc_cnt = 0;
    item_t exp_q[$];

    subleq_emu u0 (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .opcode (opcode),
        .opa    (opa),
        .opb    (opb),
        .busy   (busy),
        .done   (done),
        .err    (err),
        .result (result)
    );

    always #2 clk = ~clk;

    always @(posedge clk) cyc_cnt <= cyc_cnt + 1;

    function automatic logic [31:0] model(logic [2:0] op, logic [31:0] a, logic [31:0] b);
        case (op)
            3'd0:    return b + a;
            3'd1:    return b - a;
            3'd2:    return a - b;
            3'd3:    return b + 32'd1;
            3'd4:    return b - 32'd1;
            3'd5:    return a;
            default: return 32'd0;
        endcase
    endfunction

    function automatic int lat(logic [2:0] op);
        case (op)
            3'd0, 3'd3: return 4;
            3'd1, 3'd2, 3'd4: return 2;
            3'd5:    return 5;
            default: return 0;
        endcase
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Driver: waits for idle, issues one request, records expectation
    task automatic issue(logic [2:0] op, logic [31:0] a, logic [31:0] b, string req);
        item_t it;
        while (busy) @(negedge clk);
        start  = 1'b1;
        opcode = op;
        opa    = a;
        opb    = b;
        it.res = model(op, a, b);
        it.err = (op > 3'd5);
        it.cyc = cyc_cnt + 1 + lat(op);
        it.req = req;
        exp_q.push_back(it);
        @(negedge clk);
        start = 1'b0;
    endtask

    // Monitor: compares each completion against the scoreboard
    always @(negedge clk) begin
        if (rst_n && done) begin
            check("R11", "busy at done", {31'd0, busy}, 32'd0);
            if (exp_q.size() == 0) begin
                n_chk++;
                n_bad++;
                $display("FAIL R10 unexpected done: actual 1 expected 0");
            end else begin
                item_t it;
                it = exp_q.pop_front();
                check(it.req, "result", result, it.res);
                check(it.req, "err", {31'd0, err}, {31'd0, it.err});
                check(it.req, "done cycle", cyc_cnt, it.cyc);
            end
        end
    end

    task automatic drain();
        int guard;
        guard = 0;
        while ((exp_q.size() != 0 || busy) && guard < 100) begin
            @(negedge clk);
            guard++;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1", "done", {31'd0, done}, 32'd0);
        check("R1", "err", {31'd0, err}, 32'd0);
        check("R1", "busy", {31'd0, busy}, 32'd0);
        check("R1", "result", result, 32'd0);

        // R2 R4: ADD, accepted request goes busy
        issue(3'd0, 32'd7, 32'd5, "R4");
        check("R2", "busy after accept", {31'd0, busy}, 32'd1);
        drain();
        issue(3'd0, 32'hFFFF_FFFF, 32'd1, "R4");
        issue(3'd0, 32'hFFFF_FFF0, 32'h8000_0005, "R4");
        // R5: SUB / RSB, positive and negative differences
        issue(3'd1, 32'd3, 32'd10, "R5");
        issue(3'd1, 32'd10, 32'd3, "R5");
        issue(3'd2, 32'd3, 32'd10, "R5");
        issue(3'd2, 32'd10, 32'd10, "R5");
        // R6: INC / DEC across wrap points
        issue(3'd3, 32'd0, 32'h7FFF_FFFF, "R6");
        issue(3'd3, 32'd0, 32'hFFFF_FFFF, "R6");
        issue(3'd4, 32'd0, 32'd0, "R6");
        issue(3'd4, 32'd0, 32'd5, "R6");
        // R7: MOV
        issue(3'd5, 32'hDEAD_BEEF, 32'h1234_5678, "R7");
        issue(3'd5, 32'd0, 32'hFFFF_FFFF, "R7");
        // R9: unsupported codes
        issue(3'd6, 32'd1, 32'd2, "R9");
        issue(3'd7, 32'd1, 32'd2, "R9");
        drain();

        // R8: back-to-back ops that all depend on a clear scratch cell
        issue(3'd3, 32'd0, 32'd41, "R8");
        issue(3'd0, 32'd100, 32'd23, "R8");
        issue(3'd5, 32'd77, 32'd0, "R8");
        issue(3'd0, 32'd9, 32'd9, "R8");
        issue(3'd3, 32'd0, 32'd0, "R8");
        drain();

        // R10: start held with another request while ADD runs
        begin
            item_t it;
            while (busy) @(negedge clk);
            start  = 1'b1;
            opcode = 3'd0;
            opa    = 32'd20;
            opb    = 32'd22;
            it.res = 32'd42;
            it.err = 1'b0;
            it.cyc = cyc_cnt + 1 + 4;
            it.req = "R10";
            exp_q.push_back(it);
            @(negedge clk);
            opcode = 3'd5;
            opa    = 32'd99;
            opb    = 32'd98;
            repeat (3) @(negedge clk);
            start = 1'b0;
        end
        drain();
        check("R10", "pending items", exp_q.size(), 32'd0);

        finish_run();
    end

endmodule